// File: doc/BRIEF.md
# Flag Word and Condition Tester

This block keeps the status flags of a processor inside a 16-bit flag control word and answers branch-condition questions about them. The carry, zero, sign, decimal-adjust, parity/overflow and half-carry flags occupy fixed positions in the word. Every other bit of the word reads as zero here, because the non-flag control bits belong to other logic.

An execution unit writes results into any subset of the six flags through a per-flag write enable. Separately, a flag command can set, clear or invert any chosen group of the four arithmetic flags (carry, zero, sign, parity/overflow). A 4-bit condition selector is evaluated against the stored flags every cycle. The result drives conditional jumps and returns. A test-condition path forces bit 0 of a supplied destination word to one when the condition holds and passes the rest of that word through unchanged.

Top module: `flag_word_unit`

## Requirements
- R1: The word `fcw` holds C at bit 7, Z at bit 6, S at bit 5, D at bit 4, P/V at bit 3 and H at bit 2. All other bits read 0. With `rst` high at a rising edge the whole word becomes 0, and any execution-unit write in that cycle is ignored.
- R2: `cmd_op` = 2'b01 sets to 1 every flag selected in `cmd_mask` at the next rising edge. The mask bits are: bit 3 = C, bit 2 = Z, bit 1 = S, bit 0 = P/V.
- R3: `cmd_op` = 2'b10 clears every flag selected in `cmd_mask` at the next rising edge.
- R4: `cmd_op` = 2'b11 inverts every flag selected in `cmd_mask` at the next rising edge.
- R5: A flag command never changes D or H, and never changes a flag whose mask bit is 0.
- R6: When `ex_we[i]` is 1, flag i takes `ex_val[i]` at the next rising edge. The index order is [5]=C, [4]=Z, [3]=S, [2]=D, [1]=P/V, [0]=H. A flag with no write and no command keeps its value. `cmd_op` = 2'b00 issues no command.
- R7: When a flag command and an execution-unit write target the same flag in one cycle, the command decides that flag. The write still applies to flags outside the command's mask.
- R8: `cond_true` is evaluated from the stored word with this encoding of `cond_sel`: 0 never; 4 overflow/parity-even (V=1); 5 minus (S=1); 6 zero/equal (Z=1); 8 always; 12 no-overflow/parity-odd (V=0); 13 plus (S=0); 14 nonzero/not-equal (Z=0).
- R9: The signed codes are: 1 less-than (S xor V = 1); 2 less-or-equal (Z=1 or S xor V = 1); 9 greater-or-equal (S xor V = 0); 10 greater-than (Z=0 and S xor V = 0).
- R10: The unsigned codes are: 7 carry/unsigned-less-than (C=1); 15 no-carry/unsigned-greater-or-equal (C=0); 3 unsigned-less-or-equal (C=1 or Z=1); 11 unsigned-greater-than (C=0 and Z=0).
- R11: `tcc_word` equals `tcc_dest`, except that bit 0 is forced to 1 when `cond_true` is 1. When the condition is false, bit 0 keeps the value from `tcc_dest`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_op | input | 2 | Flag command: 00 none, 01 set, 10 clear, 11 invert |
| cmd_mask | input | 4 | Flags the command acts on: C, Z, S, P/V from bit 3 down |
| ex_we | input | 6 | Execution-unit write enable per flag |
| ex_val | input | 6 | Execution-unit flag values |
| cond_sel | input | 4 | Condition selector |
| tcc_dest | input | 16 | Destination word for the test-condition path |
| fcw | output | 16 | Registered flag control word |
| cond_true | output | 1 | Condition result |
| tcc_word | output | 16 | Destination word with bit 0 updated by the condition |

## Verification
The bench drives every one of the 16 condition codes against all 16 combinations of C, Z, S and P/V. A swapped code, a wrong signed or unsigned term, or a sign xor overflow replaced by a plain sign test would therefore miss on some pattern.

It also issues commands and execution-unit writes to the same flag in the same cycle. A design with the priority reversed, or one that drops the whole execution-unit write instead of only the contested flags, would show a wrong carry or zero bit.

Invert commands are given a full mask while D and H are set. A command decoder that reaches bit 4 or bit 2 would flip them.

The test-condition path is checked with destination bit 0 both 0 and 1 under false conditions. A design that clears the bit instead of leaving it alone would fail these checks.

Reset is applied while the execution unit is writing, to confirm that reset wins.

// File: rtl/flagcc_pkg.sv
`timescale 1ns/1ps
package flagcc_pkg;

    // Word geometry
    localparam int FCW_W   = 16;
    localparam int FLAG_N  = 6;
    localparam int FCW_LSB = 2;
    localparam int CMD_N   = 4;

    // Index of each flag inside the packed flag vector (fcw bit = index + FCW_LSB)
    localparam int F_H = 0;
    localparam int F_V = 1;
    localparam int F_D = 2;
    localparam int F_S = 3;
    localparam int F_Z = 4;
    localparam int F_C = 5;

    typedef enum logic [1:0] {
        FOP_NONE = 2'd0,
        FOP_SET  = 2'd1,
        FOP_CLR  = 2'd2,
        FOP_INV  = 2'd3
    } fop_e;

    // Lower three selector bits pick a base test; bit 3 inverts it.
    typedef enum logic [2:0] {
        CB_NEVER = 3'd0,
        CB_LT    = 3'd1,
        CB_LE    = 3'd2,
        CB_ULE   = 3'd3,
        CB_OV    = 3'd4,
        CB_MI    = 3'd5,
        CB_EQ    = 3'd6,
        CB_ULT   = 3'd7
    } cond_base_e;

    typedef struct packed {
        logic [FLAG_N-1:0] flags;
    } fw_state_t;

    // Command-mask bit that controls a flag, or -1 if commands cannot reach it
    function automatic int cmd_bit(input int f);
        case (f)
            F_C:     return 3;
            F_Z:     return 2;
            F_S:     return 1;
            F_V:     return 0;
            default: return -1;
        endcase
    endfunction

endpackage

// File: rtl/flag_cmd_apply.sv
`timescale 1ns/1ps
module flag_cmd_apply
    import flagcc_pkg::*;
#(
    parameter int N_FLAGS = FLAG_N,
    parameter int N_CMD   = CMD_N
) (
    input  logic [N_FLAGS-1:0] cur,
    input  logic [1:0]         op,
    input  logic [N_CMD-1:0]   mask,
    input  logic [N_FLAGS-1:0] ex_we,
    input  logic [N_FLAGS-1:0] ex_val,
    output logic [N_FLAGS-1:0] nxt
);

    fop_e op_e;
    assign op_e = fop_e'(op);

    for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
        localparam int MB = cmd_bit(g);
        logic nb;
        if (MB >= 0) begin : g_cmd
            always_comb begin
                if (op_e != FOP_NONE && mask[MB]) begin
                    case (op_e)
                        FOP_SET: nb = 1'b1;
                        FOP_CLR: nb = 1'b0;
                        FOP_INV: nb = ~cur[g];
                        default: nb = cur[g];
                    endcase
                end else if (ex_we[g]) begin
                    nb = ex_val[g];
                end else begin
                    nb = cur[g];
                end
            end
        end else begin : g_plain
            always_comb begin
                nb = ex_we[g] ? ex_val[g] : cur[g];
            end
        end
        assign nxt[g] = nb;
    end

endmodule

// File: rtl/cond_eval.sv
`timescale 1ns/1ps
module cond_eval
    import flagcc_pkg::*;
#(
    parameter int N_FLAGS = FLAG_N
) (
    input  logic [N_FLAGS-1:0] flags,
    input  logic [3:0]         sel,
    output logic               hit
);

    logic       sv_d;
    logic       base_d;
    cond_base_e base_sel;

    assign base_sel = cond_base_e'(sel[2:0]);

    always_comb begin
        sv_d = flags[F_S] ^ flags[F_V];
        case (base_sel)
            CB_NEVER: base_d = 1'b0;
            CB_LT:    base_d = sv_d;
            CB_LE:    base_d = flags[F_Z] | sv_d;
            CB_ULE:   base_d = flags[F_C] | flags[F_Z];
            CB_OV:    base_d = flags[F_V];
            CB_MI:    base_d = flags[F_S];
            CB_EQ:    base_d = flags[F_Z];
            CB_ULT:   base_d = flags[F_C];
            default:  base_d = 1'b0;
        endcase
        hit = base_d ^ sel[3];
    end

endmodule

// File: rtl/tcc_merge.sv
`timescale 1ns/1ps
module tcc_merge #(
    parameter int W = 16
) (
    input  logic [W-1:0] dest,
    input  logic         hit,
    output logic [W-1:0] word
);

    always_comb begin
        word    = dest;
        word[0] = dest[0] | hit;
    end

endmodule

// File: rtl/flag_word_unit.sv
`timescale 1ns/1ps
module flag_word_unit
    import flagcc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       cmd_op,
    input  logic [CMD_N-1:0] cmd_mask,
    input  logic [FLAG_N-1:0] ex_we,
    input  logic [FLAG_N-1:0] ex_val,
    input  logic [3:0]       cond_sel,
    input  logic [FCW_W-1:0] tcc_dest,
    output logic [FCW_W-1:0] fcw,
    output logic             cond_true,
    output logic [FCW_W-1:0] tcc_word
);

    localparam int POS_C = FCW_LSB + F_C;
    localparam int POS_Z = FCW_LSB + F_Z;
    localparam int POS_S = FCW_LSB + F_S;
    localparam int POS_D = FCW_LSB + F_D;
    localparam int POS_H = FCW_LSB + F_H;

    fw_state_t         st_d, st_q;
    logic [FLAG_N-1:0] nxt_flags;

    flag_cmd_apply #(.N_FLAGS(FLAG_N), .N_CMD(CMD_N)) u_apply (
        .cur    (st_q.flags),
        .op     (cmd_op),
        .mask   (cmd_mask),
        .ex_we  (ex_we),
        .ex_val (ex_val),
        .nxt    (nxt_flags)
    );

    cond_eval #(.N_FLAGS(FLAG_N)) u_cond (
        .flags (st_q.flags),
        .sel   (cond_sel),
        .hit   (cond_true)
    );

    tcc_merge #(.W(FCW_W)) u_tcc (
        .dest (tcc_dest),
        .hit  (cond_true),
        .word (tcc_word)
    );

    always_comb begin
        st_d       = st_q;
        st_d.flags = nxt_flags;
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    always_comb begin
        fcw = '0;
        fcw[FCW_LSB +: FLAG_N] = st_q.flags;
    end

    // Assertions
    p_reset_clears_r1: assert property (@(posedge clk)
        rst |=> (fcw == '0));

    p_set_carry_r2: assert property (@(posedge clk) disable iff (rst)
        (cmd_op == 2'b01 && cmd_mask[3]) |=> fcw[POS_C]);

    p_clear_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd_op == 2'b10 && cmd_mask[2]) |=> !fcw[POS_Z]);

    p_invert_sign_r4: assert property (@(posedge clk) disable iff (rst)
        (cmd_op == 2'b11 && cmd_mask[1] && !ex_we[F_S]) |=> (fcw[POS_S] != $past(fcw[POS_S])));

    p_dh_untouched_r5: assert property (@(posedge clk) disable iff (rst)
        (ex_we[F_D] == 1'b0 && ex_we[F_H] == 1'b0) |=> ($stable(fcw[POS_D]) && $stable(fcw[POS_H])));

    p_ex_write_r6: assert property (@(posedge clk) disable iff (rst)
        (cmd_op == 2'b00 && ex_we[F_C]) |=> (fcw[POS_C] == $past(ex_val[F_C])));

    p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (cmd_op == 2'b00 && ex_we == '0) |=> $stable(fcw));

    p_cmd_priority_r7: assert property (@(posedge clk) disable iff (rst)
        (cmd_op == 2'b10 && cmd_mask[3] && ex_we[F_C] && ex_val[F_C]) |=> !fcw[POS_C]);

    p_always_true_r8: assert property (@(posedge clk) disable iff (rst)
        (cond_sel == 4'd8) |-> cond_true);

    p_tcc_false_keeps_r11: assert property (@(posedge clk) disable iff (rst)
        !cond_true |-> (tcc_word == tcc_dest));

endmodule

// File: tb/flag_word_unit_tb.sv
`timescale 1ns/1ps
module flag_word_unit_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  cmd_op;
    logic [3:0]  cmd_mask;
    logic [5:0]  ex_we;
    logic [5:0]  ex_val;
    logic [3:0]  cond_sel;
    logic [15:0] tcc_dest;
    logic [15:0] fcw;
    logic        cond_true;
    logic [15:0] tcc_word;

    always #5 clk = ~clk;

    flag_word_unit u_dut (
        .clk       (clk),
        .rst       (rst),
        .cmd_op    (cmd_op),
        .cmd_mask  (cmd_mask),
        .ex_we     (ex_we),
        .ex_val    (ex_val),
        .cond_sel  (cond_sel),
        .tcc_dest  (tcc_dest),
        .fcw       (fcw),
        .cond_true (cond_true),
        .tcc_word  (tcc_word)
    );

    typedef struct {
        int          due;
        int          kind;
        logic [15:0] exp;
        string       tag;
    } item_t;

    item_t      sb[$];
    int         cyc_cnt = 0;
    int         n_chk   = 0;
    int         n_fail  = 0;
    logic [5:0] mf;
    bit         done    = 0;

    always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

    // Reference condition table, flag order {C,Z,S,D,V,H}
    function automatic logic ref_cond(input logic [3:0] sel, input logic [5:0] f);
        logic c, z, s, v;
        c = f[5]; z = f[4]; s = f[3]; v = f[1];
        case (sel)
            4'd0:  return 1'b0;
            4'd1:  return s != v;
            4'd2:  return z || (s != v);
            4'd3:  return c || z;
            4'd4:  return v;
            4'd5:  return s;
            4'd6:  return z;
            4'd7:  return c;
            4'd8:  return 1'b1;
            4'd9:  return s == v;
            4'd10: return !z && (s == v);
            4'd11: return !c && !z;
            4'd12: return !v;
            4'd13: return !s;
            4'd14: return !z;
            default: return !c;
        endcase
    endfunction

    function automatic string cond_tag(input logic [3:0] sel);
        case (sel)
            4'd1, 4'd2, 4'd9, 4'd10:  return "R9";
            4'd3, 4'd7, 4'd11, 4'd15: return "R10";
            default:                  return "R8";
        endcase
    endfunction

    task automatic push(input int due, input int kind, input logic [15:0] e, input string tag);
        item_t it;
        it.due = due; it.kind = kind; it.exp = e; it.tag = tag;
        sb.push_back(it);
    endtask

    // One cycle of stimulus; expectations go to the scoreboard
    task automatic drive(input logic [1:0] op, input logic [3:0] mask,
                         input logic [5:0] we, input logic [5:0] val,
                         input logic [3:0] sel, input logic [15:0] dest,
                         input string tag);
        logic       h;
        logic [5:0] nf;
        int         mb;
        @(posedge clk); #1;
        cmd_op = op; cmd_mask = mask; ex_we = we; ex_val = val;
        cond_sel = sel; tcc_dest = dest;
        h = ref_cond(sel, mf);
        push(cyc_cnt, 1, {15'b0, h}, cond_tag(sel));
        push(cyc_cnt, 2, {dest[15:1], h ? 1'b1 : dest[0]}, "R11");
        for (int i = 0; i < 6; i++) begin
            mb = (i == 5) ? 3 : (i == 4) ? 2 : (i == 3) ? 1 : (i == 1) ? 0 : -1;
            nf[i] = we[i] ? val[i] : mf[i];
            if (mb >= 0 && op != 2'b00 && mask[mb]) begin
                nf[i] = (op == 2'b01) ? 1'b1 : (op == 2'b10) ? 1'b0 : ~mf[i];
            end
        end
        mf = nf;
        push(cyc_cnt + 1, 0, {8'b0, mf, 2'b0}, tag);
    endtask

    task automatic pulse_reset();
        @(posedge clk); #1;
        rst = 1'b1;
        cmd_op = 2'b00; cmd_mask = 4'h0;
        ex_we = 6'h3F; ex_val = 6'h3F;   // must be ignored while reset
        mf = '0;
        push(cyc_cnt + 1, 0, 16'h0000, "R1");
        @(posedge clk); #1;
        rst = 1'b0;
        ex_we = 6'h00; ex_val = 6'h00;
    endtask

    // Monitor
    initial begin
        logic [15:0] act;
        item_t       it;
        forever begin
            @(negedge clk);
            while (sb.size() > 0 && sb[0].due <= cyc_cnt) begin
                it = sb.pop_front();
                case (it.kind)
                    0:       act = fcw;
                    1:       act = {15'b0, cond_true};
                    default: act = tcc_word;
                endcase
                n_chk++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s kind=%0d cycle=%0d actual=%h expected=%h",
                             it.tag, it.kind, cyc_cnt, act, it.exp);
                end
            end
        end
    end

    // Watchdog
    initial begin
        #1_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        cmd_op = 2'b00; cmd_mask = 4'h0; ex_we = 6'h00; ex_val = 6'h00;
        cond_sel = 4'd0; tcc_dest = 16'h0000;
        mf = '0;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        push(cyc_cnt, 0, 16'h0000, "R1");

        // R6: execution unit writes all flags -> 0xFC
        drive(2'b00, 4'h0, 6'h3F, 6'h3F, 4'd8, 16'h1234, "R6");
        // R3/R5: clear C,Z,S,V; D,H stay -> 0x14
        drive(2'b10, 4'hF, 6'h00, 6'h00, 4'd6, 16'h0001, "R3");
        // R2: set C and S
        drive(2'b01, 4'hA, 6'h00, 6'h00, 4'd7, 16'h0000, "R2");
        // R4/R5: invert all four, D and H must hold
        drive(2'b11, 4'hF, 6'h00, 6'h00, 4'd0, 16'h0003, "R4");
        drive(2'b11, 4'h5, 6'h00, 6'h00, 4'd5, 16'hFFFE, "R5");
        // R7: set carry while execution unit writes C=0 and Z=1
        drive(2'b01, 4'h8, 6'h30, 6'h10, 4'd3, 16'h8000, "R7");
        // R7: clear zero while execution unit writes Z=1 and H=0
        drive(2'b10, 4'h4, 6'h11, 6'h10, 4'd14, 16'h4001, "R7");
        // R6: command with empty mask leaves execution write intact
        drive(2'b01, 4'h0, 6'h24, 6'h04, 4'd12, 16'h0000, "R6");
        // R6: idle hold
        drive(2'b00, 4'h0, 6'h00, 6'h00, 4'd15, 16'h7777, "R6");

        // R8/R9/R10/R11: all codes against all C,Z,S,V patterns
        for (int p = 0; p < 16; p++) begin
            drive(2'b00, 4'h0, 6'b111010,
                  {p[3], p[2], p[1], 1'b0, p[0], 1'b0}, 4'd0, 16'h0000, "R6");
            for (int s = 0; s < 16; s++) begin
                drive(2'b00, 4'h0, 6'h00, 6'h00, 4'(s),
                      16'h5A5A ^ {4'(p), 4'(s), 4'(p), 4'(s)}, "R6");
            end
        end

        // R1: reset after flags are set, with execution writes pending
        drive(2'b00, 4'h0, 6'h3F, 6'h3F, 4'd8, 16'h0000, "R6");
        pulse_reset();
        drive(2'b00, 4'h0, 6'h00, 6'h00, 4'd14, 16'h0001, "R1");
        drive(2'b00, 4'h0, 6'h00, 6'h00, 4'd0, 16'h0000, "R1");

        repeat (3) @(posedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule